// File: doc/BRIEF.md
# Base Address Window Decoder

This block keeps a bank of base address registers for a device function and maps each incoming request address to one of them. Every slot is set up at elaboration as unused, an I/O window, a 32-bit memory window or the low half of a 64-bit memory window, with a window size and a prefetchable flag. The window size is rounded up to a power of two. That rounded size sets which address bits software may write into the register and which bits the decoder compares.

Software programs the window bases through a plain write port and reads them back through a combinational read port. The request side presents a 64-bit address and a flag that says whether the access is I/O or memory. One clock later the block reports whether a window claimed the address, the index of the slot that claimed it and the byte offset inside that window. When a 64-bit window is configured, the slot after it holds the upper 32 address bits and is never reported by itself. Parameter checks at elaboration reject a 64-bit window placed in the last slot.

Top module: `bar_matcher`

## Requirements
- R1: After reset every slot reads back as its fixed type bits alone (default configuration: slot 1 reads 0x00000001, slot 2 reads 0x0000000C, all others 0x00000000), and hit_o, idx_o and offset_o are zero.
- R2: A write stores only the address bits that the slot's mask allows. The type bits (bit 0 = I/O, bit 2 = 64-bit, bit 3 = prefetchable) keep their configured values. A write to an index with no slot (6 or 7) changes nothing.
- R3: The mask is the window size rounded up to a power of two, minus one, cleared from a base of 0xFFFFFFFC for I/O slots and 0xFFFFFFF0 for memory slots. Writing 0xFFFFFFFF to the default slots reads back 0xFFFFF000, 0xFFFFFFE1, 0xFFF0000C, 0xFFFFFFFF, 0x00000000 and 0xFFFFFC00.
- R4: An I/O slot can only hit when io_i is 1, and a memory slot can only hit when io_i is 0.
- R5: In a 64-bit window, address bits 63:32 are compared against the slot after the low slot. A hit reports the index of the low slot, and the upper slot is never reported.
- R6: A 32-bit memory slot or an I/O slot compares only address bits 31:0.
- R7: An unused slot never hits and always reads zero.
- R8: On a hit, offset_o is the request address with the window's mask bits cleared, upper address bits included.
- R9: When several windows claim an address, the lowest index wins.
- R10: hit_o, idx_o and offset_o reflect the address presented on the previous clock. On a miss all three are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W (3) | Slot index to write |
| wr_data_i | input | 32 | Write data |
| rd_idx_i | input | IDX_W (3) | Slot index to read |
| rd_data_o | output | 32 | Read data (combinational) |
| addr_i | input | 64 | Request address |
| io_i | input | 1 | 1 = I/O access, 0 = memory access |
| hit_o | output | 1 | A window claimed the previous address |
| idx_o | output | IDX_W (3) | Index of the claiming slot |
| offset_o | output | 64 | Offset inside the claiming window |

## Verification
Suppose a slot register holds a wrong base or a corrupted type bit. That fault shows on rd_data_o in the same cycle the slot is read. It also shows one clock after any address aimed at that window is presented: hit_o drops, or idx_o names the wrong slot. A wrong mask shows up as an offset carrying base bits, or as a hit on an address just outside the window. The bench therefore aims addresses inside, and one bit outside, the programmed windows and compares all three decode outputs one clock later.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_IO    = 2'd1,
    BAR_MEM32 = 2'd2,
    BAR_MEM64 = 2'd3
  } bar_kind_e;

  localparam int MAX_BARS = 16;

  // round size up to a power of two, minus one
  function automatic logic [63:0] pow2_mask(logic [63:0] size);
    logic [63:0] m;
    m = (size == 64'd0) ? 64'd0 : size - 64'd1;
    for (int k = 0; k < 6; k++) m = m | (m >> (1 << k));
    return m;
  endfunction

  function automatic logic [31:0] lo_mask(bar_kind_e kind, logic [63:0] size);
    logic [63:0] sm;
    sm = pow2_mask(size);
    case (kind)
      BAR_IO:    return 32'hFFFF_FFFC & ~sm[31:0];
      BAR_MEM32,
      BAR_MEM64: return 32'hFFFF_FFF0 & ~sm[31:0];
      default:   return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] hi_mask(logic [63:0] size);
    logic [63:0] sm;
    sm = pow2_mask(size);
    return ~sm[63:32];
  endfunction

  function automatic logic [31:0] type_bits(bar_kind_e kind, logic pref);
    case (kind)
      BAR_IO:    return 32'h1;
      BAR_MEM32: return {28'h0, pref, 3'b000};
      BAR_MEM64: return {28'h0, pref, 3'b100};
      default:   return 32'h0;
    endcase
  endfunction

  // slots consumed as upper half of a 64-bit pair
  function automatic logic [MAX_BARS-1:0] upper_map(logic [2*MAX_BARS-1:0] kinds, int n);
    logic [MAX_BARS-1:0] u;
    u = '0;
    for (int i = 0; i < MAX_BARS - 1; i++) begin
      if (i + 1 < n && !u[i] && bar_kind_e'(kinds[2*i +: 2]) == BAR_MEM64) u[i+1] = 1'b1;
    end
    return u;
  endfunction

endpackage

// File: rtl/bar_reg.sv
module bar_reg #(
  parameter logic [31:0] MASK = 32'h0,
  parameter logic [31:0] TYPE = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  logic [31:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (we_i) addr_q <= wdata_i & MASK;
  end

  assign q_o = addr_q | TYPE;
endmodule

// File: rtl/bar_cmp.sv
module bar_cmp
  import bar_pkg::*;
#(
  parameter bar_kind_e   KIND    = BAR_NONE,
  parameter logic [31:0] LO_MASK = 32'h0,
  parameter logic [31:0] HI_MASK = 32'h0
) (
  input  logic [63:0] addr_i,
  input  logic        io_i,
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output logic        hit_o,
  output logic [63:0] off_o
);
  localparam logic        WIDE   = (KIND == BAR_MEM64);
  localparam logic [63:0] MASK64 = WIDE ? {HI_MASK, LO_MASK} : {32'h0, LO_MASK};
  localparam logic        LIVE   = (KIND != BAR_NONE) && (LO_MASK != 32'h0);

  logic kind_ok;
  logic addr_eq;

  always_comb begin
    kind_ok = (KIND == BAR_IO) ? io_i : !io_i;
    addr_eq = (((addr_i ^ {hi_i, lo_i}) & MASK64) == 64'h0);
    hit_o   = LIVE && kind_ok && addr_eq;
    off_o   = addr_i & ~MASK64;
  end
endmodule

// File: rtl/bar_pick.sv
module bar_pick #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]       hit_i,
  input  logic [N-1:0][63:0] off_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [63:0]        off_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    off_o = '0;
    // descending scan so the lowest index is assigned last
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        off_o = off_i[i];
      end
    end
  end
endmodule

// File: rtl/bar_matcher.sv
module bar_matcher
  import bar_pkg::*;
#(
  parameter int                      NUM_BARS  = 6,
  parameter logic [2*NUM_BARS-1:0]   BAR_KINDS = 12'h836,
  parameter logic [64*NUM_BARS-1:0]  BAR_SIZES = {64'h300, 64'h0, 64'h0,
                                                  64'h10_0000, 64'h20, 64'h1000},
  parameter logic [NUM_BARS-1:0]     BAR_PREF  = 6'b000100,
  localparam int                     IDX_W     = $clog2(NUM_BARS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o,
  input  logic [63:0]      addr_i,
  input  logic             io_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [63:0]      offset_o
);
  localparam int                  SLOTS = 1 << IDX_W;
  localparam logic [MAX_BARS-1:0] UPPER =
    upper_map((2*MAX_BARS)'(BAR_KINDS), NUM_BARS);

  logic [SLOTS-1:0][31:0]    q_ext;
  logic [NUM_BARS-1:0]       hit_vec;
  logic [NUM_BARS-1:0][63:0] off_vec;
  logic                      pick_hit;
  logic [IDX_W-1:0]          pick_idx;
  logic [63:0]               pick_off;

  if (NUM_BARS > MAX_BARS) begin : g_too_many
    $error("bar_matcher: NUM_BARS above supported maximum");
  end
  if (bar_kind_e'(BAR_KINDS[2*(NUM_BARS-1) +: 2]) == BAR_MEM64 && !UPPER[NUM_BARS-1])
  begin : g_bad_last
    $error("bar_matcher: last slot is 64-bit with no upper partner");
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    localparam bar_kind_e   KIND    = bar_kind_e'(BAR_KINDS[2*i +: 2]);
    localparam logic [63:0] SZ      = BAR_SIZES[64*i +: 64];
    localparam logic [63:0] SZ_PREV = BAR_SIZES[64*((i == 0) ? 0 : i - 1) +: 64];
    localparam logic        IS_UP   = UPPER[i];
    localparam logic [31:0] R_MASK  = IS_UP ? hi_mask(SZ_PREV) : lo_mask(KIND, SZ);
    localparam logic [31:0] R_TYPE  = IS_UP ? 32'h0 : type_bits(KIND, BAR_PREF[i]);
    localparam bar_kind_e   C_KIND  = IS_UP ? BAR_NONE : KIND;

    bar_reg #(
      .MASK (R_MASK),
      .TYPE (R_TYPE)
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_idx_i == IDX_W'(i))),
      .wdata_i (wr_data_i),
      .q_o     (q_ext[i])
    );

    bar_cmp #(
      .KIND    (C_KIND),
      .LO_MASK (lo_mask(C_KIND, SZ)),
      .HI_MASK (hi_mask(SZ))
    ) u_cmp (
      .addr_i (addr_i),
      .io_i   (io_i),
      .lo_i   (q_ext[i]),
      .hi_i   (q_ext[i+1]),
      .hit_o  (hit_vec[i]),
      .off_o  (off_vec[i])
    );
  end

  for (genvar j = NUM_BARS; j < SLOTS; j++) begin : g_pad
    assign q_ext[j] = '0;
  end

  assign rd_data_o = q_ext[rd_idx_i];

  bar_pick #(
    .N     (NUM_BARS),
    .IDX_W (IDX_W)
  ) u_pick (
    .hit_i (hit_vec),
    .off_i (off_vec),
    .hit_o (pick_hit),
    .idx_o (pick_idx),
    .off_o (pick_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      idx_o    <= '0;
      offset_o <= '0;
    end else begin
      hit_o    <= pick_hit;
      idx_o    <= pick_idx;
      offset_o <= pick_off;
    end
  end
endmodule

// File: rtl/bar_matcher_chk.sv
module bar_matcher_chk
  import bar_pkg::*;
#(
  parameter int                     NUM_BARS  = 6,
  parameter logic [2*NUM_BARS-1:0]  BAR_KINDS = '0,
  parameter logic [64*NUM_BARS-1:0] BAR_SIZES = '0,
  parameter logic [NUM_BARS-1:0]    BAR_PREF  = '0,
  parameter int                     IDX_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [31:0]      rd_data_o,
  input logic [63:0]      addr_i,
  input logic             io_i,
  input logic             hit_o,
  input logic [IDX_W-1:0] idx_o,
  input logic [63:0]      offset_o
);
  localparam logic [MAX_BARS-1:0] UPPER =
    upper_map((2*MAX_BARS)'(BAR_KINDS), NUM_BARS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BARS - 1);

  bar_kind_e   sel_kind;
  logic        sel_up;
  logic [31:0] sel_mask;
  logic [31:0] rd_mask;
  logic [31:0] rd_type;

  always_comb begin
    sel_kind = BAR_NONE;
    sel_up   = 1'b0;
    sel_mask = '0;
    rd_mask  = '0;
    rd_type  = '0;
    for (int k = 0; k < NUM_BARS; k++) begin
      if (idx_o == IDX_W'(k)) begin
        sel_kind = bar_kind_e'(BAR_KINDS[2*k +: 2]);
        sel_up   = UPPER[k];
        sel_mask = lo_mask(sel_kind, BAR_SIZES[64*k +: 64]);
      end
      if (rd_idx_i == IDX_W'(k)) begin
        if (UPPER[k]) begin
          rd_mask = hi_mask(BAR_SIZES[64*((k == 0) ? 0 : k - 1) +: 64]);
        end else begin
          rd_mask = lo_mask(bar_kind_e'(BAR_KINDS[2*k +: 2]), BAR_SIZES[64*k +: 64]);
          rd_type = type_bits(bar_kind_e'(BAR_KINDS[2*k +: 2]), BAR_PREF[k]);
        end
      end
    end
  end

  // R10
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (idx_o == '0 && offset_o == 64'h0));

  // R4
  kind_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((sel_kind == BAR_IO) == $past(io_i)));

  // R7
  live_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (sel_kind != BAR_NONE && !sel_up));

  // R8
  offset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((offset_o[31:0] & sel_mask) == 32'h0));

  // R10
  offset_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (offset_o[1:0] == $past(addr_i[1:0])));

  // R2
  type_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i <= LAST) |-> ((rd_data_o & ~rd_mask) == rd_type));
endmodule

bind bar_matcher bar_matcher_chk #(
  .NUM_BARS  (NUM_BARS),
  .BAR_KINDS (BAR_KINDS),
  .BAR_SIZES (BAR_SIZES),
  .BAR_PREF  (BAR_PREF),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .addr_i    (addr_i),
  .io_i      (io_i),
  .hit_o     (hit_o),
  .idx_o     (idx_o),
  .offset_o  (offset_o)
);

// File: tb/bar_matcher_tb.sv
`timescale 1ns/1ps
module bar_matcher_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;
  logic [63:0] addr_i = '0;
  logic        io_i = 1'b0;
  logic        hit_o;
  logic [2:0]  idx_o;
  logic [63:0] offset_o;

  int checks = 0;
  int errors = 0;

  // expected masks and type bits for the default configuration (R3)
  logic [31:0] m_mask [6] = '{32'hFFFFF000, 32'hFFFFFFE0, 32'hFFF00000,
                               32'hFFFFFFFF, 32'h0, 32'hFFFFFC00};
  logic [31:0] m_type [6] = '{32'h0, 32'h1, 32'hC, 32'h0, 32'h0, 32'h0};
  logic [31:0] m_bar  [6];

  always #4 clk_i = ~clk_i;

  bar_matcher u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .rd_idx_i, .rd_data_o,
    .addr_i, .io_i, .hit_o, .idx_o, .offset_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] full_mask(int b);
    if (b == 2) return {m_mask[3], m_mask[2]};
    return {32'h0, m_mask[b]};
  endfunction

  function automatic logic [63:0] full_base(int b, logic [31:0] hi);
    if (b == 2) return {m_bar[3], m_bar[2]};
    return {hi, m_bar[b]};
  endfunction

  task automatic model(input logic [63:0] a, input bit io, output bit h,
                       output logic [2:0] ix, output logic [63:0] off);
    h = 0; ix = 0; off = 0;
    for (int b = 0; b < 6; b++) begin
      bit kind_ok;
      if (b == 3 || b == 4 || h) continue;
      kind_ok = (b == 1) ? io : !io;
      if (kind_ok && ((a ^ full_base(b, a[63:32])) & full_mask(b)) == 64'h0) begin
        h = 1; ix = 3'(b); off = a & ~full_mask(b);
      end
    end
  endtask

  task automatic wr(input logic [2:0] ix, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = ix; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (ix < 6) m_bar[ix] = (d & m_mask[ix]) | m_type[ix];
  endtask

  task automatic rd_check(input logic [2:0] ix, input logic [31:0] exp, input string req);
    rd_idx_i = ix;
    #1;
    check(rd_data_o == exp, req, 64'(rd_data_o), 64'(exp));
  endtask

  task automatic dec_check(input logic [63:0] a, input bit io, input string req);
    bit eh; logic [2:0] ei; logic [63:0] eo;
    @(negedge clk_i);
    addr_i = a; io_i = io;
    @(negedge clk_i);
    model(a, io, eh, ei, eo);
    check(hit_o == eh, req, 64'(hit_o), 64'(eh));
    check(idx_o == ei, req, 64'(idx_o), 64'(ei));
    check(offset_o == eo, req, offset_o, eo);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int b = 0; b < 6; b++) m_bar[b] = m_type[b];
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int b = 0; b < 6; b++) rd_check(3'(b), m_type[b], "R1 reset readback");
    check(hit_o == 0 && offset_o == 0 && idx_o == 0, "R1 reset outputs",
          64'(hit_o), 64'h0);
    rst_ni = 1'b1;

    // R3 mask readback of all-ones writes
    for (int b = 0; b < 6; b++) wr(3'(b), 32'hFFFF_FFFF);
    for (int b = 0; b < 6; b++) rd_check(3'(b), m_mask[b] | m_type[b], "R3 mask");
    // R2 type bits stay fixed, out-of-range writes change nothing
    wr(3'd2, 32'h0000_0000);
    rd_check(3'd2, 32'h0000_000C, "R2 type bits");
    wr(3'd6, 32'h1234_5678);
    wr(3'd7, 32'h8765_4321);
    for (int b = 0; b < 6; b++) rd_check(3'(b), m_bar[b], "R2 no-slot write");
    // R7 unused slot reads zero
    wr(3'd4, 32'hDEAD_BEEF);
    rd_check(3'd4, 32'h0, "R7 unused readback");

    wr(3'd0, 32'hF000_0000);
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h4000_0000);
    wr(3'd3, 32'h0000_0012);
    wr(3'd5, 32'hA000_0000);
    // R4 I/O versus memory
    dec_check(64'h1004, 1'b1, "R4 io hit");
    check(hit_o && idx_o == 1 && offset_o == 64'h4, "R4 io hit idx", 64'(idx_o), 64'h1);
    dec_check(64'h1004, 1'b0, "R4 io addr as mem");
    check(!hit_o, "R4 io addr as mem miss", 64'(hit_o), 64'h0);
    dec_check(64'hF000_0010, 1'b1, "R4 mem addr as io");
    check(!hit_o, "R4 mem addr as io miss", 64'(hit_o), 64'h0);
    // R5 64-bit window
    dec_check(64'h12_4001_2345, 1'b0, "R5 wide hit");
    check(hit_o && idx_o == 2 && offset_o == 64'h1_2345, "R5 wide idx", offset_o, 64'h1_2345);
    dec_check(64'h13_4001_2345, 1'b0, "R5 upper mismatch");
    check(!hit_o, "R5 upper mismatch miss", 64'(hit_o), 64'h0);
    // R6 and R8 narrow window ignores upper bits, offset keeps them
    dec_check(64'hFFFF_FFFF_F000_0010, 1'b0, "R6 narrow");
    check(hit_o && idx_o == 0 && offset_o == 64'hFFFF_FFFF_0000_0010, "R8 offset",
          offset_o, 64'hFFFF_FFFF_0000_0010);
    // R7 unused slot never hits
    dec_check(64'hDEAD_B000, 1'b0, "R7 unused never hits");
    check(!hit_o, "R7 unused miss", 64'(hit_o), 64'h0);
    // R9 lowest index wins on overlap
    wr(3'd5, 32'hF000_0000);
    dec_check(64'hF000_0100, 1'b0, "R9 overlap");
    check(idx_o == 0, "R9 lowest index", 64'(idx_o), 64'h0);
    wr(3'd0, 32'h0100_0000);
    dec_check(64'hF000_0100, 1'b0, "R9 second slot");
    check(idx_o == 5 && offset_o == 64'h100, "R9 second slot idx", 64'(idx_o), 64'h5);
    // R10 one-cycle latency
    @(negedge clk_i);
    addr_i = 64'h1008; io_i = 1'b1;
    #1;
    check(idx_o == 5, "R10 before edge", 64'(idx_o), 64'h5);
    @(negedge clk_i);
    check(hit_o && idx_o == 1 && offset_o == 64'h8, "R10 after edge", 64'(idx_o), 64'h1);

    // random mix: writes, readback, near and off-window decodes
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0) begin
        logic [2:0] ix;
        ix = 3'($urandom % 8);
        wr(ix, $urandom);
        if (ix < 6) rd_check(ix, m_bar[ix], "R2 random write");
      end else begin
        int b;
        logic [63:0] a, fm;
        bit io;
        b = $urandom % 6;
        fm = full_mask(b);
        a = (full_base(b, $urandom) & fm) | ({$urandom, $urandom} & ~fm);
        if ($urandom % 4 == 0) a = a ^ (64'h1 << ($urandom % 64));
        io = (b == 1) ^ ($urandom % 5 == 0);
        dec_check(a, io, "R8 random decode");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule